// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the configuration words of a frequency synthesizer: a 9-bit feedback divide value (M), a 2-bit output divide code (N) and a 3-bit test-select code (T). Two paths can write them. The first is a wide parallel path. While its active-low load strobe is low, the M and N inputs flow into the registers, and the registers keep the last value once the strobe rises. The second is a three-wire serial path. A 14-bit shift register takes one data bit on each rising edge of the serial clock, and the edges of a separate serial strobe move its contents into the working registers.

The whole block runs on one system clock. The parallel strobe, the serial clock, the serial strobe and the serial data are treated as synchronous to that clock. The block finds edges on these inputs by comparing each one with its value in the previous cycle. Every register change therefore appears one system clock after the input that caused it.

A flag reports when the stored M value lies outside the range in which the loop can lock. The value is still stored.

Top module: `cfg_loader`

## Requirements
- R1: After the asynchronous active-low reset, M = 0, N = 0, T = 000 and the serial output is 0.
- R2: While `par_load_n` is low, M and N take the values of `m_in` and `n_in` one clock later, and T is forced to 000. Serial strobe edges and serial clock edges do not change M, N or T in this state.
- R3: After `par_load_n` rises, and while no serial transfer event occurs, M, N and T keep their values whatever `m_in` and `n_in` do.
- R4: While `par_load_n` is high, each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the 14-bit shift register. `sr_out` is bit 13 of that register.
- R5: A 14-bit frame is sent T2 first, then T1, T0, N1, N0, M8 down to M0. After the frame, register bits [13:11] hold T, bits [10:9] hold N and bits [8:0] hold M.
- R6: A rising edge of `ser_load` while `par_load_n` is high copies shift register bits [8:0] into M. N and T are unchanged.
- R7: A falling edge of `ser_load` while `par_load_n` is high copies bits [8:0] into M, bits [10:9] into N and bits [13:11] into T.
- R8: While `ser_load` stays high and `par_load_n` is high, each rising edge of `ser_clk` also loads M from bits [8:0] of the shift register as it stands after that shift.
- R9: When a serial strobe edge falls in the same clock as a serial clock rising edge, the transfer takes the shift register contents after that clock's shift.
- R10: `m_bad` is high exactly when the stored M is below 125 or above 360. Out-of-range values are still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Parallel load strobe: transparent while low, holds after it rises |
| m_in | input | 9 | Parallel feedback divide value |
| n_in | input | 2 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial transfer strobe; both edges act |
| m_val | output | 9 | Stored feedback divide value |
| n_val | output | 2 | Stored output divide code |
| t_val | output | 3 | Stored test-select code |
| sr_out | output | 1 | Most significant bit of the shift register |
| m_bad | output | 1 | High when m_val is outside 125..360 |

## Verification
A serial clock rising edge and a serial strobe edge can fall in the same system clock, so a shift and a transfer happen together. The bench drives the falling strobe edge and the serial clock rising edge on the same negative clock edge. It then expects N and T from the frame as shifted, and M from the shift register after the extra bit has entered. A second overlap is a serial strobe edge while the parallel strobe is low. The bench toggles `ser_load` in that state and expects M and N to keep following the parallel inputs. Before these cases, a sweep of all 512 parallel M values checks the stored value and the range flag against values computed in the bench.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int MW    = 9,
  parameter int NW    = 2,
  parameter int TW    = 3,
  parameter int M_MIN = 125,
  parameter int M_MAX = 360
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          par_load_n,
  input  logic [MW-1:0] m_in,
  input  logic [NW-1:0] n_in,
  input  logic          ser_clk,
  input  logic          ser_data,
  input  logic          ser_load,
  output logic [MW-1:0] m_val,
  output logic [NW-1:0] n_val,
  output logic [TW-1:0] t_val,
  output logic          sr_out,
  output logic          m_bad
);
  localparam int FW = TW + NW + MW;
  localparam logic [MW-1:0] M_LO = MW'(M_MIN);
  localparam logic [MW-1:0] M_HI = MW'(M_MAX);

  logic          sclk_q, sload_q;
  logic [FW-1:0] sr, sr_nxt;

  wire sclk_rise  = ser_clk & ~sclk_q;
  wire sload_rise = ser_load & ~sload_q;
  wire sload_fall = ~ser_load & sload_q;

  assign sr_nxt = sclk_rise ? {sr[FW-2:0], ser_data} : sr;
  assign sr_out = sr[FW-1];
  assign m_bad  = (m_val < M_LO) || (m_val > M_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sload_q <= 1'b0;
      sr      <= '0;
      m_val   <= '0;
      n_val   <= '0;
      t_val   <= '0;
    end else begin
      sclk_q  <= ser_clk;
      sload_q <= ser_load;
      if (par_load_n) sr <= sr_nxt;
      if (!par_load_n) begin
        m_val <= m_in;
        n_val <= n_in;
        t_val <= '0;
      end else if (sload_fall) begin
        {t_val, n_val, m_val} <= sr_nxt;
      end else if (sload_rise || (ser_load && sclk_rise)) begin
        m_val <= sr_nxt[MW-1:0];
      end
    end
  end

  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !par_load_n |=> (m_val == $past(m_in) && n_val == $past(n_in) && t_val == '0)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (par_load_n && ser_load == sload_q && !(ser_load && sclk_rise))
      |=> ($stable(m_val) && $stable(n_val) && $stable(t_val))); // R3
  AST_NT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (par_load_n && !sload_fall) |=> ($stable(n_val) && $stable(t_val))); // R6
  AST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (par_load_n && sclk_rise) |=> (sr_out == $past(sr[FW-2]))); // R4
  AST_SR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise) |=> $stable(sr_out)); // R4
endmodule

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
  logic clk = 0, rst_n = 0;
  logic par_load_n = 0, ser_clk = 0, ser_data = 0, ser_load = 0;
  logic [8:0] m_in = 0;
  logic [1:0] n_in = 0;
  logic [8:0] m_val;
  logic [1:0] n_val;
  logic [2:0] t_val;
  logic sr_out, m_bad;

  int checks = 0, fails = 0;
  logic [13:0] model = 0;
  logic [8:0] em;
  logic [1:0] en;
  logic [2:0] et;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_loader dut (.clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .m_in(m_in),
    .n_in(n_in), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .m_val(m_val), .n_val(n_val), .t_val(t_val), .sr_out(sr_out), .m_bad(m_bad));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    chk({tag, " M"}, m_val, em);
    chk({tag, " N"}, n_val, en);
    chk({tag, " T"}, t_val, et);
  endtask

  function automatic int bad(int m);
    return (m < 125 || m > 360) ? 1 : 0;
  endfunction

  task automatic sbit(bit b);
    ser_data = b; ser_clk = 1;
    model = {model[12:0], b};
    if (ser_load) em = model[8:0];
    @(negedge clk);
    ser_clk = 0;
    @(negedge clk);
  endtask

  task automatic sframe(logic [2:0] t, logic [1:0] n, logic [8:0] m);
    logic [13:0] f;
    f = {t, n, m};
    for (int i = 13; i >= 0; i--) begin
      sbit(f[i]);
      chk("R4 sr_out", sr_out, model[13]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 M", m_val, 0); chk("R1 N", n_val, 0); chk("R1 T", t_val, 0);
    chk("R1 sr_out", sr_out, 0);
    rst_n = 1;
    @(negedge clk);

    for (int m = 0; m < 512; m++) begin
      m_in = 9'(m); n_in = 2'(m % 4);
      @(negedge clk);
      chk("R2 M", m_val, m); chk("R2 N", n_val, m % 4);
      chk("R2 T", t_val, 0); chk("R10 flag", m_bad, bad(m));
    end

    m_in = 9'd200; n_in = 2'd1; em = 200; en = 1; et = 0;
    @(negedge clk);
    par_load_n = 1;
    @(negedge clk);
    m_in = 9'd77; n_in = 2'd3;
    repeat (2) @(negedge clk);
    chk_regs("R3 hold");

    sframe(3'b101, 2'b10, 9'd300);
    chk_regs("R5 frame no transfer");
    ser_load = 1; em = 300;
    @(negedge clk);
    chk_regs("R6 rise");
    chk("R10 in range", m_bad, 0);
    ser_load = 0; en = 2; et = 5;
    @(negedge clk);
    chk_regs("R7 fall");
    chk("R5 T field", t_val, 5);

    sframe(3'b011, 2'b01, 9'd400);
    ser_load = 1; em = 400;
    @(negedge clk);
    chk_regs("R6 rise2");
    chk("R10 out of range stored", m_bad, 1);
    for (int i = 0; i < 5; i++) begin
      sbit(i[0]);
      chk_regs("R8 follow");
    end

    ser_data = 1; ser_clk = 1; ser_load = 0;
    model = {model[12:0], 1'b1};
    {et, en, em} = model;
    @(negedge clk);
    chk_regs("R9 same cycle");
    ser_clk = 0;
    @(negedge clk);

    par_load_n = 0; m_in = 9'd125; n_in = 2'd0;
    @(negedge clk);
    ser_load = 1;
    @(negedge clk);
    ser_load = 0; m_in = 9'd361;
    @(negedge clk);
    chk("R2 override M", m_val, 361); chk("R2 T forced", t_val, 0);
    chk("R10 361", m_bad, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule